// File: doc/BRIEF.md
# SPI Target Controller with Receive and Transmit Byte Rings

This block connects an external SPI master to a local register-style host port. It shifts SPI mode 0 (clock idle low, sample on the rising edge, MSB first). Each received byte goes into a receive ring buffer. Each byte clocked in also clocks one byte out. That byte comes from a transmit ring buffer, or is a programmable filler value when the transmit ring is empty. Both rings hold `DEPTH` bytes. `DEPTH` must be a power of two.

The hardware advances the receive write pointer and the transmit read pointer. The host owns the receive read pointer and the transmit write pointer and moves them itself. Each pointer carries one wrap bit above the ring index, so a full ring can be told apart from an empty one. The host reads fill levels from one register. It inspects the receive byte at its read pointer through a peek register, and places a transmit byte at its write pointer through a poke register. Two level outputs signal the host:
- `ev_rx` flags that received data is waiting.
- `ev_cs` flags that chip select has been released.

Top module: `spi_tgt_dualfifo`

Register map (word address on `h_addr`):

| Addr | Access | Contents |
|------|--------|----------|
| 0 | read/write | bit 0 receive enable; bit 1 receive clear (write-only pulse) |
| 1 | read/write | filler byte in bits 7:0 |
| 2 | read/write | receive read pointer |
| 3 | read-only | receive write pointer |
| 4 | read/write | transmit write pointer |
| 5 | read-only | transmit read pointer |
| 6 | read-only | fill levels: receive count in bits 15:0, transmit count in bits 31:16 |
| 7 | read/write-1-to-clear | bit 0 overflow, bit 1 chip-select-release event |
| 8 | read-only | receive byte at the receive read pointer, in bits 7:0 |
| 9 | write | transmit byte, stored at the transmit write pointer |

Pointers are `$clog2(DEPTH)+1` bits wide, and the low bits form the ring index.

## Requirements
- R1: After eight rising SCK edges with chip select low, the byte assembled MSB first from MOSI is stored at the receive write pointer index. That pointer (address 3) then advances by one. The byte is readable at address 8 once the receive read pointer (address 2) points at it.
- R2: MISO presents each transmit byte MSB first and is valid before the first rising SCK edge of every byte. The transmit read pointer (address 5) advances by one for each completed byte that came from the transmit ring.
- R3: When the transmit ring is empty at the start of a byte, the filler byte from address 1 bits 7:0 is sent instead. The filler byte resets to 0xFF.
- R4: The host-owned pointers (addresses 2 and 4) take the written value. The hardware pointers (addresses 3 and 5) ignore writes. Address 6 returns the receive count (write minus read) in bits 15:0 and the transmit count in bits 31:16.
- R5: Pointers run modulo 2*DEPTH, and the ring index is the pointer modulo DEPTH. A byte received after DEPTH earlier bytes therefore lands at index zero again.
- R6: When a byte completes while the receive count equals DEPTH, the byte is dropped, the write pointer holds, and overflow (address 7 bit 0) is set. The flag stays set until the host writes 1 to that bit.
- R7: Receive enable is address 0 bit 0 and resets to 0. While it is 0, completed bytes are not stored. Writing 1 to address 0 bit 1 returns both receive pointers to zero.
- R8: `ev_rx` is high exactly when receive is enabled and the receive count is nonzero.
- R9: When chip select goes high, `ev_cs` and address 7 bit 1 are set. They stay set until the host writes 1 to address 7 bit 1.
- R10: A byte cut short by chip select going high is discarded. The bit counter restarts with the next frame. A transmit-ring byte that was not fully sent is offered again at the next frame and is not consumed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock from the master |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| h_we | input | 1 | Host write strobe |
| h_addr | input | 4 | Host register address |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, combinational from `h_addr` |
| ev_rx | output | 1 | Receive data waiting |
| ev_cs | output | 1 | Chip select released (sticky) |

## Verification
Full-duplex traffic runs under three transmit conditions:
- An empty transmit ring with the reset filler, which separates the 0xFF reset value from a programmed filler.
- A ring holding fewer bytes than the frame, which shows that the ring drains in order and the filler follows without a gap.
- A ring byte pending when a frame is cut after four bits, which shows that an unfinished byte is neither consumed nor stored.

On the receive side, the test feeds:
- Bytes while the ring is disabled.
- Exactly DEPTH bytes, followed by one more to force overflow.
- A refill after the ring drains, which lands at index zero and so exercises the wrap of the pointer index against its wrap bit.

// File: rtl/spi_tgt_dualfifo.sv
module spi_tgt_dualfifo #(
  parameter int DEPTH = 1024,
  parameter logic [7:0] FILL_RST = 8'hFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk,
  input  logic        cs_n,
  input  logic        mosi,
  output logic        miso,
  input  logic        h_we,
  input  logic [3:0]  h_addr,
  input  logic [31:0] h_wdata,
  output logic [31:0] h_rdata,
  output logic        ev_rx,
  output logic        ev_cs
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [2:0] sclk_q, cs_q;
  logic [1:0] mosi_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk};
      cs_q   <= {cs_q[1:0], cs_n};
      mosi_q <= {mosi_q[0], mosi};
    end

  logic sck_rise, sck_fall, cs_act, cs_start, cs_end, mosi_s;
  assign sck_rise = sclk_q[1] & ~sclk_q[2];
  assign sck_fall = ~sclk_q[1] & sclk_q[2];
  assign cs_act   = ~cs_q[1];
  assign cs_start = ~cs_q[1] & cs_q[2];
  assign cs_end   = cs_q[1] & ~cs_q[2];
  assign mosi_s   = mosi_q[1];

  logic [7:0] rx_mem [DEPTH];
  logic [7:0] tx_mem [DEPTH];
  logic [PW-1:0] rx_wp, rx_rp, tx_wp, tx_rp, rx_cnt, tx_cnt;
  logic [7:0] fill, tx_sh;
  logic [6:0] rx_sh;
  logic [2:0] bit_cnt;
  logic rx_en, ovf, csev, cur_fifo, reload;

  assign rx_cnt = rx_wp - rx_rp;
  assign tx_cnt = tx_wp - tx_rp;

  logic byte_done, rx_full, rx_clr, rx_store;
  logic [7:0] rx_byte;
  assign byte_done = cs_act & sck_rise & (bit_cnt == 3'd7);
  assign rx_byte   = {rx_sh, mosi_s};
  assign rx_full   = (rx_cnt == PW'(DEPTH));
  assign rx_clr    = h_we & (h_addr == 4'd0) & h_wdata[1];
  assign rx_store  = byte_done & rx_en & ~rx_full & ~rx_clr;

  logic wr_fill, wr_rrp, wr_twp, wr_flag, wr_poke;
  assign wr_fill = h_we & (h_addr == 4'd1);
  assign wr_rrp  = h_we & (h_addr == 4'd2);
  assign wr_twp  = h_we & (h_addr == 4'd4);
  assign wr_flag = h_we & (h_addr == 4'd7);
  assign wr_poke = h_we & (h_addr == 4'd9);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_en <= 1'b0;
      fill  <= FILL_RST;
      rx_wp <= '0;
      rx_rp <= '0;
      tx_wp <= '0;
      ovf   <= 1'b0;
      csev  <= 1'b0;
    end else begin
      if (h_we && h_addr == 4'd0) rx_en <= h_wdata[0];
      if (wr_fill) fill <= h_wdata[7:0];
      if (wr_twp) tx_wp <= h_wdata[PW-1:0];
      if (rx_clr) begin
        rx_wp <= '0;
        rx_rp <= '0;
      end else begin
        if (rx_store) rx_wp <= rx_wp + 1'b1;
        if (wr_rrp) rx_rp <= h_wdata[PW-1:0];
      end
      if (byte_done && rx_en && rx_full) ovf <= 1'b1;
      else if (wr_flag && h_wdata[0]) ovf <= 1'b0;
      if (cs_end) csev <= 1'b1;
      else if (wr_flag && h_wdata[1]) csev <= 1'b0;
    end

  always_ff @(posedge clk)
    if (rx_store) rx_mem[rx_wp[AW-1:0]] <= rx_byte;

  always_ff @(posedge clk)
    if (wr_poke) tx_mem[tx_wp[AW-1:0]] <= h_wdata[7:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_sh    <= FILL_RST;
      cur_fifo <= 1'b0;
      reload   <= 1'b0;
      tx_rp    <= '0;
    end else begin
      reload <= 1'b0;
      if (!cs_act) bit_cnt <= '0;
      if (cs_start || reload) begin
        cur_fifo <= (tx_cnt != '0);
        tx_sh    <= (tx_cnt != '0) ? tx_mem[tx_rp[AW-1:0]] : fill;
      end else if (cs_act && sck_rise) begin
        rx_sh   <= {rx_sh[5:0], mosi_s};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          reload <= 1'b1;
          if (cur_fifo) tx_rp <= tx_rp + 1'b1;
        end
      end else if (cs_act && sck_fall && bit_cnt != 3'd0) begin
        tx_sh <= {tx_sh[6:0], 1'b0};
      end
    end

  assign miso  = tx_sh[7];
  assign ev_rx = rx_en & (rx_cnt != '0);
  assign ev_cs = csev;

  always_comb begin
    h_rdata = '0;
    case (h_addr)
      4'd0: h_rdata[0]    = rx_en;
      4'd1: h_rdata[7:0]  = fill;
      4'd2: h_rdata[PW-1:0] = rx_rp;
      4'd3: h_rdata[PW-1:0] = rx_wp;
      4'd4: h_rdata[PW-1:0] = tx_wp;
      4'd5: h_rdata[PW-1:0] = tx_rp;
      4'd6: h_rdata = {{(16-PW){1'b0}}, tx_cnt, {(16-PW){1'b0}}, rx_cnt};
      4'd7: h_rdata[1:0]  = {csev, ovf};
      4'd8: h_rdata[7:0]  = rx_mem[rx_rp[AW-1:0]];
      default: h_rdata = '0;
    endcase
  end

  logic unused_bits;
  assign unused_bits = ^h_wdata[31:8];
endmodule

// File: rtl/spi_tgt_dualfifo_chk.sv
module spi_tgt_dualfifo_chk #(
  parameter int DEPTH = 1024
) (
  input logic clk,
  input logic rst_n,
  input logic h_we,
  input logic [3:0] h_addr,
  input logic [31:0] h_wdata,
  input logic rx_en,
  input logic [$clog2(DEPTH):0] rx_wp,
  input logic [$clog2(DEPTH):0] rx_rp,
  input logic [$clog2(DEPTH):0] tx_rp,
  input logic ovf,
  input logic cs_end,
  input logic byte_done,
  input logic ev_rx,
  input logic ev_cs
);
  localparam int PW = $clog2(DEPTH) + 1;
  logic clr, ovf_clr;
  logic [PW-1:0] fill_lvl;
  assign clr = h_we && h_addr == 4'd0 && h_wdata[1];
  assign ovf_clr = h_we && h_addr == 4'd7 && h_wdata[0];
  assign fill_lvl = rx_wp - rx_rp;

  AST_RX_WP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (rx_wp == $past(rx_wp) || rx_wp == PW'($past(rx_wp) + 1'b1))); // R1
  AST_TX_RP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (tx_rp == $past(tx_rp) || tx_rp == PW'($past(tx_rp) + 1'b1))); // R2
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && fill_lvl == PW'(DEPTH) && !clr) |=> $stable(rx_wp)); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf); // R6
  AST_NO_STORE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !clr) |=> $stable(rx_wp)); // R7
  AST_RX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (rx_wp == '0 && rx_rp == '0)); // R7
  AST_EV_RX_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_wp == rx_rp) |-> !ev_rx); // R8
  AST_CS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    cs_end |=> ev_cs); // R9
endmodule

bind spi_tgt_dualfifo spi_tgt_dualfifo_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
  .rx_en(rx_en), .rx_wp(rx_wp), .rx_rp(rx_rp), .tx_rp(tx_rp), .ovf(ovf),
  .cs_end(cs_end), .byte_done(byte_done), .ev_rx(ev_rx), .ev_cs(ev_cs)
);

// File: tb/spi_tgt_dualfifo_tb_top.sv
module spi_tgt_dualfifo_tb_top;
  localparam int DEPTH = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, miso;
  logic h_we = 1'b0;
  logic [3:0] h_addr = '0;
  logic [31:0] h_wdata = '0, h_rdata;
  logic ev_rx, ev_cs;
  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  spi_tgt_dualfifo #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .ev_rx(ev_rx), .ev_cs(ev_cs));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic hwr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    h_addr = a; h_wdata = d; h_we = 1'b1;
    @(negedge clk);
    h_we = 1'b0;
  endtask

  task automatic chk_reg(input string tag, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk);
    h_addr = a;
    #1;
    check(tag, h_rdata, exp);
  endtask

  task automatic half();
    repeat (8) @(negedge clk);
  endtask

  task automatic cs_on();
    @(negedge clk); cs_n = 1'b0; half();
  endtask

  task automatic cs_off();
    half(); cs_n = 1'b1; repeat (12) @(negedge clk);
  endtask

  task automatic spi_byte(input logic [7:0] mo, input logic [7:0] exp_mi, input string tag);
    exp_q.push_back(exp_mi);
    tag_q.push_back(tag);
    for (int i = 7; i >= 0; i--) begin
      mosi = mo[i]; half(); sclk = 1'b1; half(); sclk = 1'b0;
    end
  endtask

  task automatic frame1(input logic [7:0] mo, input logic [7:0] exp_mi, input string tag);
    cs_on(); spi_byte(mo, exp_mi, tag); cs_off();
  endtask

  task automatic poke(input logic [7:0] b, input int wp);
    hwr(4'd9, {24'd0, b});
    hwr(4'd4, wp);
  endtask

  // monitor: pops expected MISO bytes as full bytes complete
  initial begin
    logic [7:0] mbyte;
    int mbits;
    mbits = 0; mbyte = '0;
    forever begin
      @(posedge sclk or posedge cs_n);
      if (cs_n) mbits = 0;
      else begin
        mbyte = {mbyte[6:0], miso};
        mbits++;
        if (mbits == 8) begin
          mbits = 0;
          if (exp_q.size() == 0) check("R2 unexpected miso byte", {24'd0, mbyte}, 32'hFFFF_FFFF);
          else check({tag_q.pop_front(), " miso byte"}, {24'd0, mbyte}, {24'd0, exp_q.pop_front()});
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_reg("R3 filler reset", 4'd1, 32'hFF);
    chk_reg("R7 enable reset", 4'd0, 32'h0);
    chk_reg("R4 levels reset", 4'd6, 32'h0);
    check("R8 ev_rx reset", {31'd0, ev_rx}, 32'd0);
    check("R9 ev_cs reset", {31'd0, ev_cs}, 32'd0);

    hwr(4'd0, 32'h1);
    frame1(8'hA5, 8'hFF, "R3");
    check("R9 ev_cs set", {31'd0, ev_cs}, 32'd1);
    chk_reg("R9 flag bit", 4'd7, 32'h2);
    chk_reg("R1 rx wp", 4'd3, 32'd1);
    chk_reg("R1 peek", 4'd8, 32'hA5);
    check("R8 ev_rx set", {31'd0, ev_rx}, 32'd1);
    hwr(4'd7, 32'h2);
    check("R9 ev_cs cleared", {31'd0, ev_cs}, 32'd0);

    hwr(4'd1, 32'h3C);
    chk_reg("R3 filler write", 4'd1, 32'h3C);
    frame1(8'h5A, 8'h3C, "R3");

    poke(8'h11, 1);
    poke(8'h22, 2);
    hwr(4'd5, 32'h7);
    hwr(4'd3, 32'h9);
    chk_reg("R4 hw tx rp ignores write", 4'd5, 32'd0);
    chk_reg("R4 hw rx wp ignores write", 4'd3, 32'd2);
    chk_reg("R4 levels", 4'd6, {16'd2, 16'd2});
    cs_on();
    spi_byte(8'hC1, 8'h11, "R2");
    spi_byte(8'hC2, 8'h22, "R2");
    spi_byte(8'hC3, 8'h3C, "R2");
    cs_off();
    chk_reg("R2 tx rp", 4'd5, 32'd2);
    chk_reg("R4 levels after frame", 4'd6, {16'd0, 16'd5});

    begin
      logic [7:0] rxe [5] = '{8'hA5, 8'h5A, 8'hC1, 8'hC2, 8'hC3};
      for (int i = 0; i < 5; i++) begin
        hwr(4'd2, i);
        chk_reg("R4 rx readback", 4'd8, {24'd0, rxe[i]});
      end
    end
    hwr(4'd2, 5);
    chk_reg("R4 rx rp", 4'd2, 32'd5);
    check("R8 ev_rx drained", {31'd0, ev_rx}, 32'd0);

    poke(8'h77, 3);
    cs_on();
    for (int i = 0; i < 4; i++) begin
      mosi = i[0]; half(); sclk = 1'b1; half(); sclk = 1'b0;
    end
    cs_off();
    chk_reg("R10 partial not stored", 4'd3, 32'd5);
    chk_reg("R10 partial not consumed", 4'd5, 32'd2);
    frame1(8'h9E, 8'h77, "R10");
    chk_reg("R10 realigned byte", 4'd8, 32'h9E);
    chk_reg("R10 tx consumed", 4'd5, 32'd3);
    hwr(4'd2, 6);

    hwr(4'd0, 32'h0);
    frame1(8'h44, 8'h3C, "R7");
    chk_reg("R7 disabled no store", 4'd3, 32'd6);
    check("R7 ev_rx disabled", {31'd0, ev_rx}, 32'd0);
    hwr(4'd0, 32'h1);
    frame1(8'h45, 8'h3C, "R7");
    check("R8 ev_rx pending", {31'd0, ev_rx}, 32'd1);
    hwr(4'd0, 32'h3);
    chk_reg("R7 clear rp", 4'd2, 32'd0);
    chk_reg("R7 clear wp", 4'd3, 32'd0);
    check("R8 ev_rx after clear", {31'd0, ev_rx}, 32'd0);

    cs_on();
    for (int i = 0; i < DEPTH; i++) spi_byte(8'h60 + 8'(i), 8'h3C, "R6");
    cs_off();
    chk_reg("R6 full level", 4'd6, 32'd16);
    chk_reg("R6 no overflow yet", 4'd7, 32'h2);
    frame1(8'hEE, 8'h3C, "R6");
    chk_reg("R6 overflow set", 4'd7, 32'h3);
    chk_reg("R6 wp held", 4'd3, 32'd16);
    hwr(4'd7, 32'h3);
    chk_reg("R6 overflow cleared", 4'd7, 32'h0);
    chk_reg("R6 first byte", 4'd8, 32'h60);
    hwr(4'd2, 15);
    chk_reg("R6 last byte", 4'd8, 32'h6F);

    hwr(4'd2, 16);
    cs_on();
    spi_byte(8'hD0, 8'h3C, "R5");
    spi_byte(8'hD1, 8'h3C, "R5");
    cs_off();
    chk_reg("R5 wp wrap bit", 4'd3, 32'd18);
    chk_reg("R5 index zero reused", 4'd8, 32'hD0);
    hwr(4'd2, 17);
    chk_reg("R5 index one", 4'd8, 32'hD1);
    chk_reg("R5 level across wrap", 4'd6, 32'd1);

    repeat (20) @(negedge clk);
    check("R2 all miso bytes seen", exp_q.size(), 32'd0);
    summary();
    $finish;
  end
endmodule